// File: doc/BRIEF.md
# Lane Alignment Sequence Generator

This block drives the transmit side of a multiframe-based serial link while the link is being brought up. After a start request it waits for a pulse that marks a local multiframe boundary, then sends a programmable number of alignment multiframes, each a fixed number of octets long. Every multiframe opens with a start control character and closes with an end control character. The second multiframe carries a marker character and then the link configuration octets. All other octets hold their own running position in the sequence. A per-octet flag tells the encoder downstream which octets are control characters.

When the last alignment multiframe ends, the generator enters the data phase. It raises `tx_ready` and from then on forwards the user octet on every cycle. A new start request aborts whatever is running and re-arms the generator. A synchronous reset sends it to idle.

The octets-per-multiframe value, the multiframe count and the configuration octets are captured when the start request is taken. The upstream logic may change these inputs while a sequence is running.

Top module: `lane_align_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `tx_ready`=0, `tx_ctrl`=0 and `tx_data`=0x00. The block stays in that idle condition, ignoring `mf_tick`, until `start_req` is seen.
- R2: A sampled `start_req` arms the generator and captures `oct_per_mf` (K), `mf_count` and `cfg_octets`. While armed it outputs 0x00 with `tx_ctrl`=0. Octet 0 of the first multiframe appears in the cycle after the edge that samples `mf_tick`=1.
- R3: Octet 0 of every alignment multiframe is 0x1C and octet K-1 is 0x7C, both with `tx_ctrl`=1. No two consecutive outputs are both 0x1C with `tx_ctrl`=1.
- R4: In the second multiframe (index 1), octet 1 is 0x9C with `tx_ctrl`=1. Octets 2 to NCFG+1 are configuration octets 0 to NCFG-1 with `tx_ctrl`=0, where configuration octet i sits in `cfg_octets[8*i+7:8*i]`. K must be at least NCFG+3.
- R5: Every other alignment octet p of multiframe m is (m*K + p) mod 256, with `tx_ctrl`=0.
- R6: After octet K-1, the next multiframe starts in the following cycle if `mf_tick` was sampled at that same edge. Otherwise the block outputs 0x00 with `tx_ctrl`=0 until the edge that samples `mf_tick`, and the position count does not advance during the wait.
- R7: The sequence is `mf_count` multiframes long, with 0 treated as 1. In the cycle after the final 0x7C, `tx_ready` rises. From then on `tx_data` equals `user_data` in the same cycle with `tx_ctrl`=0, and `tx_ready` stays high until reset or a new start.
- R8: `start_req` restarts from any state. In the next cycle the block is armed, with `tx_ready`=0 and output 0x00 with `tx_ctrl`=0, even if `mf_tick` is sampled at the same edge.
- R9: Changes to `oct_per_mf`, `mf_count` or `cfg_octets` after the start request has been sampled have no effect on the running sequence.
- R10: `tx_ctrl` is high only while `tx_data` is 0x1C, 0x7C or 0x9C, and never while `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Starts or restarts the alignment sequence |
| mf_tick | input | 1 | Local multiframe boundary pulse |
| oct_per_mf | input | K_W | Octets per multiframe (K) |
| mf_count | input | MF_W | Number of alignment multiframes (0 means 1) |
| cfg_octets | input | NCFG*8 | Link configuration octets, octet i at bits 8i+7:8i |
| user_data | input | 8 | User octet forwarded during the data phase |
| tx_data | output | 8 | Output octet |
| tx_ctrl | output | 1 | High when `tx_data` is a control character |
| tx_ready | output | 1 | High during the data phase |

## Verification
The bench builds the block with its default parameters: 14 configuration octets, an 8-bit octet-count field and a 4-bit multiframe count.

With these values, K=17 is the tightest legal fit. In that case the end character directly follows the last configuration octet. With K=255, the 8-bit position value wraps inside the second multiframe.

A count of 0 exercises the single-multiframe case. Random counts up to 5, together with random gaps between boundaries, cover back-to-back and delayed multiframes.

// File: rtl/lane_align_pkg.sv
// Shared types and control-character codes for the lane alignment generator.
package lane_align_pkg;

    typedef logic [7:0] octet_t;

    localparam octet_t MF_START_CHAR = 8'h1C;
    localparam octet_t MF_END_CHAR   = 8'h7C;
    localparam octet_t CFG_MARK_CHAR = 8'h9C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SEND,
        ST_GAP,
        ST_DATA
    } seq_state_e;

endpackage

// File: rtl/lane_align_cfg_store.sv
// Holds the configuration octets captured on a start request.
// Assumes: load is a single-cycle strobe from the sequencer's start input.
module lane_align_cfg_store #(
    parameter int NCFG = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NCFG*8-1:0] cfg_in,
    output logic [NCFG*8-1:0] cfg_q
);

    for (genvar gi = 0; gi < NCFG; gi++) begin : g_oct
        // Capture one configuration octet per start request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[gi*8 +: 8] <= 8'h00;
            end else if (load) begin
                cfg_q[gi*8 +: 8] <= cfg_in[gi*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/lane_align_seq_ctrl.sv
// Sequencer: tracks the phase, the multiframe index, the octet index and the
// running position of the alignment sequence.
// Assumes: k_in >= 2 when start is asserted. A start outweighs every other event.
module lane_align_seq_ctrl
    import lane_align_pkg::*;
#(
    parameter int K_W  = 8,
    parameter int MF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mf_tick,
    input  logic [K_W-1:0]   k_in,
    input  logic [MF_W-1:0]  mf_num_in,
    output seq_state_e       state,
    output logic [MF_W-1:0]  mf_idx,
    output logic [K_W-1:0]   oct_idx,
    output octet_t           seq_pos,
    output logic             at_last
);

    logic [K_W-1:0]  k_last;
    logic [MF_W-1:0] mf_last;

    // Flag the final octet of the current multiframe.
    always_comb begin
        at_last = (oct_idx == k_last);
    end

    // Phase and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mf_idx  <= '0;
            oct_idx <= '0;
            seq_pos <= 8'h00;
            k_last  <= '0;
            mf_last <= '0;
        end else if (start) begin
            state   <= ST_ARM;
            mf_idx  <= '0;
            oct_idx <= '0;
            seq_pos <= 8'h00;
            k_last  <= k_in - K_W'(1);
            mf_last <= (mf_num_in == '0) ? '0 : (mf_num_in - MF_W'(1));
        end else begin
            case (state)
                ST_ARM, ST_GAP: begin
                    if (mf_tick) begin
                        state   <= ST_SEND;
                        oct_idx <= '0;
                    end
                end
                ST_SEND: begin
                    seq_pos <= seq_pos + 8'h01;
                    if (at_last) begin
                        oct_idx <= '0;
                        if (mf_idx == mf_last) begin
                            state <= ST_DATA;
                        end else begin
                            mf_idx <= mf_idx + MF_W'(1);
                            state  <= mf_tick ? ST_SEND : ST_GAP;
                        end
                    end else begin
                        oct_idx <= oct_idx + K_W'(1);
                    end
                end
                default: begin
                    state <= state;
                end
            endcase
        end
    end

endmodule

// File: rtl/lane_align_octet_mux.sv
// Picks the output octet and control flag from the sequencer state.
// Assumes: the multiframe length leaves room for the marker and all
// configuration octets (K >= NCFG + 3).
module lane_align_octet_mux
    import lane_align_pkg::*;
#(
    parameter int NCFG = 14,
    parameter int K_W  = 8,
    parameter int MF_W = 4
) (
    input  seq_state_e        state,
    input  logic [MF_W-1:0]   mf_idx,
    input  logic [K_W-1:0]    oct_idx,
    input  logic              at_last,
    input  octet_t            seq_pos,
    input  logic [NCFG*8-1:0] cfg_q,
    input  octet_t            user_data,
    output octet_t            tx_data,
    output logic              tx_ctrl,
    output logic              tx_ready
);

    localparam int SEL_W = (NCFG > 1) ? $clog2(NCFG) : 1;
    localparam logic [K_W-1:0] CFG_FIRST = K_W'(2);
    localparam logic [K_W-1:0] CFG_END   = K_W'(NCFG + 2);

    octet_t           cfg_arr [NCFG];
    logic [K_W-1:0]   cfg_off;
    logic [SEL_W-1:0] cfg_sel;
    logic             in_cfg_mf;
    logic             in_cfg;

    for (genvar gi = 0; gi < NCFG; gi++) begin : g_unpack
        assign cfg_arr[gi] = cfg_q[gi*8 +: 8];
    end

    // Locate the configuration window inside the second multiframe.
    always_comb begin
        in_cfg_mf = (mf_idx == MF_W'(1));
        cfg_off   = oct_idx - CFG_FIRST;
        cfg_sel   = cfg_off[SEL_W-1:0];
        in_cfg    = in_cfg_mf && (oct_idx >= CFG_FIRST) && (oct_idx < CFG_END);
    end

    // Output octet selection, ordered by priority.
    always_comb begin
        tx_data  = 8'h00;
        tx_ctrl  = 1'b0;
        tx_ready = 1'b0;
        case (state)
            ST_SEND: begin
                if (oct_idx == '0) begin
                    tx_data = MF_START_CHAR;
                    tx_ctrl = 1'b1;
                end else if (at_last) begin
                    tx_data = MF_END_CHAR;
                    tx_ctrl = 1'b1;
                end else if (in_cfg_mf && oct_idx == K_W'(1)) begin
                    tx_data = CFG_MARK_CHAR;
                    tx_ctrl = 1'b1;
                end else if (in_cfg) begin
                    tx_data = cfg_arr[cfg_sel];
                end else begin
                    tx_data = seq_pos;
                end
            end
            ST_DATA: begin
                tx_data  = user_data;
                tx_ready = 1'b1;
            end
            default: begin
                tx_data = 8'h00;
            end
        endcase
    end

endmodule

// File: rtl/lane_align_gen.sv
// Top of the lane alignment sequence generator.
// Assumes: mf_tick is a one-cycle pulse on each local multiframe boundary,
// and oct_per_mf >= NCFG + 3 whenever start_req is asserted.
module lane_align_gen
    import lane_align_pkg::*;
#(
    parameter int NCFG = 14,
    parameter int K_W  = 8,
    parameter int MF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              mf_tick,
    input  logic [K_W-1:0]    oct_per_mf,
    input  logic [MF_W-1:0]   mf_count,
    input  logic [NCFG*8-1:0] cfg_octets,
    input  logic [7:0]        user_data,
    output logic [7:0]        tx_data,
    output logic              tx_ctrl,
    output logic              tx_ready
);

    seq_state_e        state;
    logic [MF_W-1:0]   mf_idx;
    logic [K_W-1:0]    oct_idx;
    octet_t            seq_pos;
    logic              at_last;
    logic [NCFG*8-1:0] cfg_q;

    lane_align_seq_ctrl #(.K_W(K_W), .MF_W(MF_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_req),
        .mf_tick   (mf_tick),
        .k_in      (oct_per_mf),
        .mf_num_in (mf_count),
        .state     (state),
        .mf_idx    (mf_idx),
        .oct_idx   (oct_idx),
        .seq_pos   (seq_pos),
        .at_last   (at_last)
    );

    lane_align_cfg_store #(.NCFG(NCFG)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_req),
        .cfg_in (cfg_octets),
        .cfg_q  (cfg_q)
    );

    lane_align_octet_mux #(.NCFG(NCFG), .K_W(K_W), .MF_W(MF_W)) u_mux (
        .state     (state),
        .mf_idx    (mf_idx),
        .oct_idx   (oct_idx),
        .at_last   (at_last),
        .seq_pos   (seq_pos),
        .cfg_q     (cfg_q),
        .user_data (user_data),
        .tx_data   (tx_data),
        .tx_ctrl   (tx_ctrl),
        .tx_ready  (tx_ready)
    );

endmodule

// File: rtl/lane_align_gen_chk.sv
// Port-level protocol checks for lane_align_gen, attached by bind.
module lane_align_gen_chk #(
    parameter int NCFG = 14,
    parameter int K_W  = 8,
    parameter int MF_W = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_req,
    input logic [7:0] tx_data,
    input logic       tx_ctrl,
    input logic       tx_ready
);

    localparam logic [7:0] C_START = 8'h1C;
    localparam logic [7:0] C_END   = 8'h7C;
    localparam logic [7:0] C_MARK  = 8'h9C;

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!tx_ready && !tx_ctrl && tx_data == 8'h00));

    a_r3_no_double_start: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ctrl && tx_data == C_START) |=> !(tx_ctrl && tx_data == C_START));

    a_r7_ready_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(tx_ctrl && tx_data == C_END));

    a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !start_req) |=> tx_ready);

    a_r8_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> (!tx_ready && !tx_ctrl && tx_data == 8'h00));

    a_r10_ctrl_legal: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ctrl |-> (!tx_ready &&
                     (tx_data == C_START || tx_data == C_END || tx_data == C_MARK)));

endmodule

bind lane_align_gen lane_align_gen_chk #(.NCFG(NCFG), .K_W(K_W), .MF_W(MF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .tx_data   (tx_data),
    .tx_ctrl   (tx_ctrl),
    .tx_ready  (tx_ready)
);

// File: tb/lane_align_gen_test.sv
// Self-checking bench: directed corner cases plus seeded random sequences.
module lane_align_gen_test;

    localparam int NCFG = 14;
    localparam int K_W  = 8;
    localparam int MF_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_req = 1'b0;
    logic              mf_tick = 1'b0;
    logic [K_W-1:0]    oct_per_mf = '0;
    logic [MF_W-1:0]   mf_count = '0;
    logic [NCFG*8-1:0] cfg_octets = '0;
    logic [7:0]        user_data = 8'h00;
    logic [7:0]        tx_data;
    logic              tx_ctrl;
    logic              tx_ready;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    lane_align_gen #(.NCFG(NCFG), .K_W(K_W), .MF_W(MF_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .mf_tick    (mf_tick),
        .oct_per_mf (oct_per_mf),
        .mf_count   (mf_count),
        .cfg_octets (cfg_octets),
        .user_data  (user_data),
        .tx_data    (tx_data),
        .tx_ctrl    (tx_ctrl),
        .tx_ready   (tx_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", req, $time, act, exp);
        end
    endtask

    // Expected {ctrl, octet} for octet p of multiframe m, from R3, R4 and R5.
    function automatic logic [8:0] exp_oct(input int m, input int p, input int k,
                                           input logic [NCFG*8-1:0] cfg);
        if (p == 0)                              return {1'b1, 8'h1C};
        if (p == k - 1)                          return {1'b1, 8'h7C};
        if (m == 1 && p == 1)                    return {1'b1, 8'h9C};
        if (m == 1 && p >= 2 && p < NCFG + 2)    return {1'b0, cfg[(p-2)*8 +: 8]};
        return {1'b0, 8'((m * k + p) % 256)};
    endfunction

    function automatic logic [NCFG*8-1:0] rand_cfg();
        logic [NCFG*8-1:0] v;
        for (int i = 0; i < NCFG; i++) v[i*8 +: 8] = 8'($urandom);
        return v;
    endfunction

    // Check the quiet output seen while armed, idle or waiting for a boundary.
    task automatic chk_quiet(input string req);
        chk(req, {23'd0, tx_ready, tx_ctrl, tx_data}, 32'd0);
    endtask

    // Full sequence: start, boundaries with random gaps, octet checks, data phase.
    task automatic run_seq(input int k, input int nmf_in);
        logic [NCFG*8-1:0] cfg_used;
        int  nm;
        bit  b2b;
        logic [8:0] e;
        string tag;
        nm = (nmf_in == 0) ? 1 : nmf_in;
        oct_per_mf = K_W'(k);
        mf_count   = MF_W'(nmf_in);
        cfg_octets = rand_cfg();
        cfg_used   = cfg_octets;
        start_req  = 1'b1;
        @(posedge clk); #1;
        start_req  = 1'b0;
        // R9: disturb captured inputs after the start was sampled.
        oct_per_mf = K_W'(17 + $urandom_range(0, 30));
        mf_count   = MF_W'($urandom_range(0, 15));
        cfg_octets = rand_cfg();
        @(negedge clk);
        chk_quiet("R2/R8 armed after start");
        @(posedge clk); #1;
        b2b = 1'b0;
        for (int m = 0; m < nm; m++) begin
            if (!b2b) begin
                int idle = $urandom_range(0, 2);
                for (int i = 0; i < idle; i++) begin
                    @(negedge clk);
                    chk_quiet(m == 0 ? "R2 armed wait" : "R6 gap wait");
                    @(posedge clk); #1;
                end
                mf_tick = 1'b1;
                @(negedge clk);
                chk_quiet(m == 0 ? "R2 tick cycle" : "R6 tick cycle");
                @(posedge clk); #1;
                mf_tick = 1'b0;
            end
            b2b = (m < nm - 1) && ($urandom_range(0, 1) == 0);
            for (int p = 0; p < k; p++) begin
                mf_tick = (p == k - 1) && b2b;
                @(negedge clk);
                e = exp_oct(m, p, k, cfg_used);
                if (p == 0 || p == k - 1)           tag = "R3 frame char";
                else if (m == 1 && p < NCFG + 2)    tag = "R4/R9 marker or cfg";
                else                                tag = "R5 position";
                chk(tag, {22'd0, tx_ready, tx_ctrl, tx_data}, {22'd0, 1'b0, e});
                @(posedge clk); #1;
                mf_tick = 1'b0;
            end
        end
        for (int i = 0; i < 4; i++) begin
            user_data = 8'($urandom);
            mf_tick   = 1'($urandom_range(0, 1));
            @(negedge clk);
            chk("R7 data phase", {23'd0, tx_ready, tx_ctrl, tx_data},
                {23'd0, 1'b1, 1'b0, user_data});
            @(posedge clk); #1;
            mf_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog R7: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state.
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk_quiet("R1 reset state");
        @(posedge clk); #1;
        rst_n = 1'b1;
        mf_tick = 1'b1;
        @(negedge clk);
        chk_quiet("R1 idle ignores tick");
        @(posedge clk); #1;
        mf_tick = 1'b0;
        @(negedge clk);
        chk_quiet("R1 still idle");
        @(posedge clk); #1;

        // R4: tightest fit K = NCFG+3.
        run_seq(NCFG + 3, 2);
        // R7: a count of 0 behaves as one multiframe.
        run_seq(20, 0);

        // R8: restart mid-sequence with a coincident boundary.
        oct_per_mf = K_W'(30);
        mf_count   = MF_W'(3);
        start_req  = 1'b1;
        @(posedge clk); #1;
        start_req  = 1'b0;
        mf_tick    = 1'b1;
        @(posedge clk); #1;
        mf_tick    = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        start_req  = 1'b1;
        mf_tick    = 1'b1;
        @(posedge clk); #1;
        start_req  = 1'b0;
        mf_tick    = 1'b0;
        @(negedge clk);
        chk_quiet("R8 restart beats tick");
        @(posedge clk); #1;

        // R5: position wraps inside the second multiframe.
        run_seq(255, 2);

        for (int r = 0; r < 6; r++) begin
            run_seq($urandom_range(NCFG + 3, 40), $urandom_range(1, 5));
        end

        // R1: reset from the data phase.
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        chk_quiet("R1 reset from data phase");
        @(posedge clk); #1;
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule